// File: doc/BRIEF.md
# Interrupt Status and Mask Unit

This unit sits beside an I2C packet controller and turns the controller's event signals into a single interrupt request. Six of the events (two completion events, two FIFO error events and two bus error events) arrive as one-cycle pulses. Each pulse latches into a sticky status bit that stays set until software clears it. The two data-request sources arrive as levels. Their status bits follow those levels and never latch.

An 8-bit enable mask selects which status bits may raise the interrupt. The interrupt line is a registered OR over the masked status. A simple register port reads and writes both registers. A mask write replaces the mask. A status write clears every sticky bit written as 1 and leaves every bit written as 0 unchanged. A driver normally follows this sequence: write 0xFF to the status register, enable the sources it cares about, wait for the interrupt, read the status, then clear the bits it has handled.

Top module: `irq_status_unit`

## Requirements
- R1: Status bit positions are fixed: 7 packet done, 6 all packets done, 5 transmit overflow, 4 receive underflow, 3 no acknowledge, 2 arbitration lost, 1 transmit data request, 0 receive data request. Pulse input `evt_pulse[k]` sets status bit k+2 on the clock edge where it is sampled high.
- R2: A set sticky status bit (7..2) keeps its value until a clearing write reaches it.
- R3: A write with `bus_addr`=1 (status register) clears each sticky bit whose `bus_wdata` bit is 1. Bits written 0 keep their value.
- R4: If an event pulse and a clearing write hit the same sticky bit on the same edge, the bit ends up set.
- R5: Status bits 1 and 0 equal the `dreq_lvl` levels sampled on the previous edge, and writes to the status register do not change them.
- R6: A write with `bus_addr`=0 loads `bus_wdata` into the mask. The new mask reads back after the edge, and the write leaves the status bits unchanged.
- R7: `irq` is high in the cycle after an edge exactly when the status AND mask values before that edge had at least one bit set.
- R8: During synchronous reset, status, mask and `irq` all go to 0.
- R9: A status write of 0xFF clears all six sticky bits in one cycle when no event pulse is present.
- R10: `bus_rdata` shows the mask when `bus_addr`=0 and the status when `bus_addr`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_pulse | input | 6 | Event pulses; bit k sets status bit k+2 |
| dreq_lvl | input | 2 | Live data-request levels (bit 1 transmit, bit 0 receive) |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register select: 0 mask, 1 status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| irq | output | 1 | Registered interrupt request |

## Verification
A sticky bit that drops early, or never drops, shows up at `bus_rdata` one edge after the pulse or clearing write that should have decided it. If that bit is enabled, it also shows on `irq` one edge later. A mask or priority fault between set and clear changes `irq` exactly two edges after the triggering input. Each cycle the bench reads back both registers and compares `irq` against a model of the status, mask and interrupt. Any such fault is therefore caught in the cycle it first becomes visible.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int STAT_W   = 8;
    localparam int LIVE_W   = 2;
    localparam int STICKY_W = STAT_W - LIVE_W;

    typedef enum logic {
        SEL_MASK = 1'b0,
        SEL_STAT = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic pkt_done;
        logic all_done;
        logic tx_ovf;
        logic rx_unf;
        logic nack;
        logic arb_lost;
        logic tx_req;
        logic rx_req;
    } stat_s;

    function automatic logic [STICKY_W-1:0] clear_bits(
        input logic              wr,
        input reg_sel_e          sel,
        input logic [STAT_W-1:0] data
    );
        if (wr && sel == SEL_STAT)
            return data[STAT_W-1:LIVE_W];
        return '0;
    endfunction
endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
    parameter int STAT_W = irq_pkg::STAT_W,
    parameter int LIVE_W = irq_pkg::LIVE_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [STAT_W-LIVE_W-1:0]   ev_i,
    input  logic [LIVE_W-1:0]          lvl_i,
    input  logic [STAT_W-LIVE_W-1:0]   clr_i,
    output logic [STAT_W-1:0]          stat_o
);
    localparam int STICKY_W = STAT_W - LIVE_W;

    logic [STICKY_W-1:0] sticky_q;
    logic [LIVE_W-1:0]   live_q;

    for (genvar i = 0; i < STICKY_W; i++) begin : g_sticky
        always_ff @(posedge clk) begin
            if (rst)
                sticky_q[i] <= 1'b0;
            else if (ev_i[i])
                sticky_q[i] <= 1'b1;
            else if (clr_i[i])
                sticky_q[i] <= 1'b0;
        end

        // R2
        hold_chk: assert property (@(posedge clk) disable iff (rst)
            (sticky_q[i] && !clr_i[i]) |=> sticky_q[i]);
        // R4
        set_wins_chk: assert property (@(posedge clk) disable iff (rst)
            ev_i[i] |=> sticky_q[i]);
        // R3
        clear_chk: assert property (@(posedge clk) disable iff (rst)
            (clr_i[i] && !ev_i[i]) |=> !sticky_q[i]);
    end

    always_ff @(posedge clk) begin
        if (rst)
            live_q <= '0;
        else
            live_q <= lvl_i;
    end

    // R5
    live_follow_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> live_q == $past(lvl_i));

    assign stat_o = {sticky_q, live_q};
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
    parameter int STAT_W = irq_pkg::STAT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we_i,
    input  logic [STAT_W-1:0] wdata_i,
    output logic [STAT_W-1:0] mask_o
);
    always_ff @(posedge clk) begin
        if (rst)
            mask_o <= '0;
        else if (we_i)
            mask_o <= wdata_i;
    end

    // R6
    mask_load_chk: assert property (@(posedge clk) disable iff (rst)
        we_i |=> mask_o == $past(wdata_i));
    // R6
    mask_keep_chk: assert property (@(posedge clk) disable iff (rst)
        !we_i |=> $stable(mask_o));
endmodule

// File: rtl/irq_combine.sv
module irq_combine #(
    parameter int STAT_W = irq_pkg::STAT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [STAT_W-1:0] stat_i,
    input  logic [STAT_W-1:0] mask_i,
    output logic              irq_o
);
    always_ff @(posedge clk) begin
        if (rst)
            irq_o <= 1'b0;
        else
            irq_o <= |(stat_i & mask_i);
    end
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit #(
    parameter int STAT_W = irq_pkg::STAT_W,
    parameter int LIVE_W = irq_pkg::LIVE_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [STAT_W-LIVE_W-1:0] evt_pulse,
    input  logic [LIVE_W-1:0]        dreq_lvl,
    input  logic                     bus_wr,
    input  logic                     bus_addr,
    input  logic [STAT_W-1:0]        bus_wdata,
    output logic [STAT_W-1:0]        bus_rdata,
    output logic                     irq
);
    import irq_pkg::*;

    localparam int STICKY_W = STAT_W - LIVE_W;

    reg_sel_e            sel;
    logic                mask_we;
    logic [STICKY_W-1:0] clr;
    logic [STAT_W-1:0]   stat;
    logic [STAT_W-1:0]   mask;

    assign sel     = reg_sel_e'(bus_addr);
    assign mask_we = bus_wr && (sel == SEL_MASK);

    always_comb begin
        clr = '0;
        if (bus_wr && sel == SEL_STAT)
            clr = bus_wdata[STAT_W-1:LIVE_W];
    end

    irq_status_bank #(.STAT_W(STAT_W), .LIVE_W(LIVE_W)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .ev_i   (evt_pulse),
        .lvl_i  (dreq_lvl),
        .clr_i  (clr),
        .stat_o (stat)
    );

    irq_mask_reg #(.STAT_W(STAT_W)) u_mask (
        .clk     (clk),
        .rst     (rst),
        .we_i    (mask_we),
        .wdata_i (bus_wdata),
        .mask_o  (mask)
    );

    irq_combine #(.STAT_W(STAT_W)) u_comb (
        .clk    (clk),
        .rst    (rst),
        .stat_i (stat),
        .mask_i (mask),
        .irq_o  (irq)
    );

    assign bus_rdata = (sel == SEL_MASK) ? mask : stat;

    // R7
    irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (|(stat & mask)) |=> irq);
    // R7
    irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !(|(stat & mask)) |=> !irq);
    // R6
    mask_wr_stat_chk: assert property (@(posedge clk) disable iff (rst)
        (mask_we && evt_pulse == '0) |=>
            stat[STAT_W-1:LIVE_W] == $past(stat[STAT_W-1:LIVE_W]));
    // R8
    reset_chk: assert property (@(posedge clk)
        rst |=> (stat == '0 && mask == '0 && !irq));
endmodule

// File: tb/tb_irq_status_unit.sv
module tb_irq_status_unit;
    localparam int W  = 8;
    localparam int LV = 2;
    localparam int SW = W - LV;

    logic          clk = 1'b0;
    logic          rst;
    logic [SW-1:0] evt_pulse;
    logic [LV-1:0] dreq_lvl;
    logic          bus_wr;
    logic          bus_addr;
    logic [W-1:0]  bus_wdata;
    logic [W-1:0]  bus_rdata;
    logic          irq;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [W-1:0] m_stat, m_mask;
    logic         m_irq;

    always #10 clk = ~clk;

    irq_status_unit dut (
        .clk       (clk),
        .rst       (rst),
        .evt_pulse (evt_pulse),
        .dreq_lvl  (dreq_lvl),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    function automatic logic [W-1:0] next_stat(input logic [W-1:0] s,
        input logic [SW-1:0] ev, input logic [LV-1:0] lv,
        input logic wr, input logic a, input logic [W-1:0] wd);
        logic [SW-1:0] clr;
        clr = (wr && a) ? wd[W-1:LV] : '0;
        return {(s[W-1:LV] & ~clr) | ev, lv};
    endfunction

    function automatic logic [W-1:0] next_mask(input logic [W-1:0] m,
        input logic wr, input logic a, input logic [W-1:0] wd);
        return (wr && !a) ? wd : m;
    endfunction

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic check_all();
        bus_wr   = 1'b0;
        bus_addr = 1'b0;
        #1 chk("R6/R10 mask", bus_rdata, m_mask);
        bus_addr = 1'b1;
        #1 chk("R1/R2/R3/R5/R10 status", bus_rdata, m_stat);
        chk("R7 irq", {7'b0, irq}, {7'b0, m_irq});
    endtask

    task automatic cycle(input logic [SW-1:0] ev, input logic [LV-1:0] lv,
        input logic wr, input logic a, input logic [W-1:0] wd);
        evt_pulse = ev; dreq_lvl = lv; bus_wr = wr; bus_addr = a; bus_wdata = wd;
        @(posedge clk);
        m_irq  = |(m_stat & m_mask);
        m_stat = next_stat(m_stat, ev, lv, wr, a, wd);
        m_mask = next_mask(m_mask, wr, a, wd);
        #2;
        evt_pulse = '0;
        check_all();
    endtask

    initial begin
        #3000000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        int seed;
        int r;
        seed = 1234;
        r = $urandom(seed);
        rst = 1'b1; evt_pulse = '0; dreq_lvl = '0; bus_wr = 1'b0;
        bus_addr = 1'b0; bus_wdata = '0;
        m_stat = '0; m_mask = '0; m_irq = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        // R8 reset state
        bus_addr = 1'b0; #1 chk("R8 mask after reset", bus_rdata, 8'h00);
        bus_addr = 1'b1; #1 chk("R8 status after reset", bus_rdata, 8'h00);
        chk("R8 irq after reset", {7'b0, irq}, 8'h00);
        @(negedge clk);
        rst = 1'b0;

        // R1: each pulse sets bit k+2 only
        for (int k = 0; k < SW; k++) begin
            cycle(6'(1 << k), 2'b00, 1'b0, 1'b0, 8'h00);
            chk("R1 bit position", bus_rdata, 8'(1 << (k + 2)) | 8'(((1 << k) - 1) << 2));
        end
        // R9: 0xFF clears every sticky bit
        cycle('0, 2'b11, 1'b1, 1'b1, 8'hFF);
        chk("R9 clear all sticky", bus_rdata & 8'hFC, 8'h00);
        // R5: live bits ignore the clear
        chk("R5 live bits kept", bus_rdata & 8'h03, 8'h03);
        // R6: mask write leaves status unchanged
        cycle(6'h01, 2'b00, 1'b0, 1'b0, 8'h00);
        cycle('0, 2'b00, 1'b1, 1'b0, 8'h04);
        chk("R6 status kept over mask write", bus_rdata, 8'h04);
        // R7: irq rises one edge after status&mask
        cycle('0, 2'b00, 1'b0, 1'b0, 8'h00);
        chk("R7 irq raised", {7'b0, irq}, 8'h01);
        // R4: set and clear on the same bit
        cycle(6'h20, 2'b00, 1'b1, 1'b1, 8'h80);
        chk("R4 set beats clear", bus_rdata & 8'h80, 8'h80);
        // R3: partial clear keeps zero-written bits
        cycle('0, 2'b00, 1'b1, 1'b1, 8'h04);
        chk("R3 partial clear", bus_rdata, 8'h80);
        // R2: hold over idle cycles
        repeat (5) cycle('0, 2'b00, 1'b0, 1'b0, 8'h00);
        chk("R2 sticky hold", bus_rdata, 8'h80);

        // random mix
        for (int n = 0; n < 3000; n++) begin
            logic [SW-1:0] ev;
            logic wr;
            ev = (($urandom % 4) == 0) ? SW'($urandom) : '0;
            wr = (($urandom % 3) == 0);
            cycle(ev, LV'($urandom), wr, 1'($urandom), W'($urandom));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule